// File: doc/BRIEF.md
# Dual Register Bus-Write Latch

This block is the digital write side of a pair of 8-bit output registers on a parallel processor bus. A shared data bus, an address select line and two active-low strobes (chip select and write) arrive asynchronously to the system clock. The block resamples them, recognises the end of a write cycle, and moves the byte into register A or register B. Both register values leave the block continuously, for use by downstream converters.

The combined strobe counts as active only while chip select and write are both low. A register loads only when that combined strobe ends, whichever of the two lines rises first. The register never follows the bus while the strobes are held low. The data byte and the select value are taken on the clock in which the combined strobe is first seen low, and they are kept until the trailing edge. A select line that moves during the active phase breaks the bus protocol. Such a change sets a sticky violation flag, which stays set until a separate clear input removes it.

Top module: `twin_reg_write_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, `reg_a`, `reg_b` and `sel_violation` become 0, whatever the bus inputs are doing. The registers stay 0 after reset until a later write completes.
- R2: A write completed with `bus_sel` = 0 loads the byte into `reg_a` and leaves `reg_b` unchanged.
- R3: A write completed with `bus_sel` = 1 loads the byte into `reg_b` and leaves `reg_a` unchanged.
- R4: A load occurs when `bus_wr_n` rises while `bus_cs_n` is low.
- R5: A load occurs when `bus_cs_n` rises while `bus_wr_n` is low.
- R6: While both strobes are held low, neither register changes, even when the data bus changes. The byte and select loaded are the ones present when the combined strobe was first seen low.
- R7: Toggling `bus_wr_n` while `bus_cs_n` stays high, or toggling `bus_cs_n` while `bus_wr_n` stays high, changes neither register.
- R8: The loaded register shows the new value on the third rising clock edge after the trailing strobe edge reaches the input, and not before.
- R9: A change of `bus_sel` while both strobes are low sets `sel_violation`. The flag then stays 1 until it is cleared.
- R10: `flag_clr` high at a clock edge clears `sel_violation`, and takes priority over a violation seen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| bus_cs_n | input | 1 | Chip select strobe, active low, asynchronous |
| bus_wr_n | input | 1 | Write strobe, active low, asynchronous |
| bus_sel | input | 1 | Destination select: 0 for register A, 1 for register B |
| bus_data | input | 8 | Shared write data bus |
| flag_clr | input | 1 | Clears the sticky violation flag (system clock domain) |
| reg_a | output | 8 | Contents of register A |
| reg_b | output | 8 | Contents of register B |
| sel_violation | output | 1 | Sticky flag: select moved during an active strobe |

## Verification
The assertions assume that the bus lines stay steady for at least two clock periods around each strobe transition. Under that assumption the two-flop resampling passes a coherent snapshot of data, select and strobes. They also assume that `flag_clr` is synchronous to `clk`. The stimulus changes every bus input on the falling clock edge only. It holds each strobe phase for at least four clock periods and changes data or select only while the strobes are idle, except in the cases that test R6 and R9 on purpose.

// File: rtl/twr_pkg.sv
// Package: shared types for the dual register bus-write latch.
// Assumes: a single select bit addresses exactly two registers.
package twr_pkg;

    // Destination register chosen by the bus select line
    typedef enum logic {
        TGT_A = 1'b0,
        TGT_B = 1'b1
    } tgt_e;

    localparam int unsigned NUM_TARGETS = 2;

endpackage

// File: rtl/twr_sync.sv
// Module: twr_sync
// Two-stage resynchronizer for a vector of asynchronous inputs.
// Assumes: each bit settles long enough that skew between bits is
// resolved by the bus protocol (inputs steady across several clocks).
module twr_sync #(
    parameter int unsigned         W       = 1,
    parameter logic [W-1:0]        RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift the asynchronous vector through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;

endmodule

// File: rtl/twr_strobe_ctrl.sv
// Module: twr_strobe_ctrl
// Forms the combined active-low strobe, captures data and select on its
// leading edge, issues a one-cycle commit on its trailing edge, and
// reports a select change during the active phase.
// Assumes: inputs are already synchronous to clk.
module twr_strobe_ctrl
    import twr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              wr_s,
    input  logic              sel_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              commit,
    output tgt_e              commit_sel,
    output logic [DATA_W-1:0] commit_data,
    output logic              sel_moved
);

    logic              strobe_s;
    logic              strobe_q;
    logic              lead_edge;
    logic              trail_edge;
    tgt_e              hold_sel;
    logic [DATA_W-1:0] hold_data;

    // Combined strobe is low only while both lines are low
    always_comb begin
        strobe_s   = cs_s | wr_s;
        lead_edge  = strobe_q & ~strobe_s;
        trail_edge = ~strobe_q & strobe_s;
    end

    // Remember the previous strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b1;
        end else begin
            strobe_q <= strobe_s;
        end
    end

    // Capture data and select on the leading edge and hold them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_sel  <= TGT_A;
            hold_data <= '0;
        end else if (lead_edge) begin
            hold_sel  <= tgt_e'(sel_s);
            hold_data <= data_s;
        end
    end

    // Outputs: commit on the trailing edge, violation during active phase
    always_comb begin
        commit      = trail_edge;
        commit_sel  = hold_sel;
        commit_data = hold_data;
        sel_moved   = ~strobe_s & ~strobe_q & (sel_s != logic'(hold_sel));
    end

endmodule

// File: rtl/twr_reg_bank.sv
// Module: twr_reg_bank
// Bank of NUM_REGS data registers. Exactly one register loads on a
// commit, chosen by the index; all others hold.
// Assumes: commit is a single-cycle pulse.
module twr_reg_bank #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 2,
    localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             commit,
    input  logic [IDX_W-1:0]                 commit_idx,
    input  logic [DATA_W-1:0]                commit_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);

    logic [NUM_REGS-1:0] load;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg

        // Decode the load enable for this register
        always_comb begin
            load[i] = commit && (commit_idx == IDX_W'(i));
        end

        // Hold or load this register, zero on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (load[i]) begin
                regs[i] <= commit_data;
            end
        end

        // R6 R7
        hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !load[i] |=> $stable(regs[i]));
    end

    // R2 R3
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));

endmodule

// File: rtl/twr_viol_flag.sv
// Module: twr_viol_flag
// Sticky protocol-violation flag with a synchronous clear that wins.
// Assumes: clr is synchronous to clk.
module twr_viol_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);

    // Set on a violation, cleared by clr or reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clr) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end
    end

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);

endmodule

// File: rtl/twin_reg_write_port.sv
// Module: twin_reg_write_port
// Top level: resynchronizes the asynchronous parallel bus, detects the
// trailing edge of the combined chip-select/write strobe and loads one of
// two registers; flags select changes during an active strobe.
// Assumes: bus lines hold steady for at least two clocks around strobe
// transitions; flag_clr is in the clk domain.
module twin_reg_write_port
    import twr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic              sel_violation
);

    localparam int unsigned PAY_W = DATA_W + 1;

    logic [1:0]                         strobes_s;
    logic [PAY_W-1:0]                   payload_s;
    logic                               commit;
    tgt_e                               commit_sel;
    logic [DATA_W-1:0]                  commit_data;
    logic                               sel_moved;
    logic [NUM_TARGETS-1:0][DATA_W-1:0] regs;

    twr_sync #(.W(2), .RST_VAL(2'b11)) u_sync_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_cs_n, bus_wr_n}),
        .sync_out (strobes_s)
    );

    twr_sync #(.W(PAY_W), .RST_VAL('0)) u_sync_payload (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_sel, bus_data}),
        .sync_out (payload_s)
    );

    twr_strobe_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (strobes_s[1]),
        .wr_s        (strobes_s[0]),
        .sel_s       (payload_s[PAY_W-1]),
        .data_s      (payload_s[DATA_W-1:0]),
        .commit      (commit),
        .commit_sel  (commit_sel),
        .commit_data (commit_data),
        .sel_moved   (sel_moved)
    );

    twr_reg_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_TARGETS)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_idx  (logic'(commit_sel)),
        .commit_data (commit_data),
        .regs        (regs)
    );

    twr_viol_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (sel_moved),
        .clr   (flag_clr),
        .flag  (sel_violation)
    );

    // Map bank entries onto the named outputs
    always_comb begin
        reg_a = regs[TGT_A];
        reg_b = regs[TGT_B];
    end

    // R2 R3 R4 R5
    write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ((($past(commit_sel) == TGT_B) ? reg_b : reg_a) == $past(commit_data)));

endmodule

// File: tb/tb_twin_reg_write_port.sv
module tb_twin_reg_write_port;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       sel;
        logic [7:0] data;
        logic       cs_first;
        logic [7:0] exp_a;
        logic [7:0] exp_b;
    } vec_t;

    // sel, data, cs released first, expected A, expected B
    localparam vec_t VECS [6] = '{
        '{1'b0, 8'h5A, 1'b0, 8'h5A, 8'h00},
        '{1'b1, 8'hC3, 1'b1, 8'h5A, 8'hC3},
        '{1'b0, 8'hFF, 1'b1, 8'hFF, 8'hC3},
        '{1'b1, 8'h00, 1'b0, 8'hFF, 8'h00},
        '{1'b1, 8'h81, 1'b0, 8'hFF, 8'h81},
        '{1'b0, 8'h3C, 1'b1, 8'h3C, 8'h81}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic       flag_clr = 1'b0;
    logic [7:0] reg_a;
    logic [7:0] reg_b;
    logic       sel_violation;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twin_reg_write_port dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_cs_n      (bus_cs_n),
        .bus_wr_n      (bus_wr_n),
        .bus_sel       (bus_sel),
        .bus_data      (bus_data),
        .flag_clr      (flag_clr),
        .reg_a         (reg_a),
        .reg_b         (reg_b),
        .sel_violation (sel_violation)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Full write cycle; the strobe released first triggers the load
    task automatic bus_write(input logic sel, input logic [7:0] data, input logic cs_first);
        @(negedge clk);
        bus_sel  = sel;
        bus_data = data;
        wait_neg(3);
        bus_cs_n = 1'b0;
        bus_wr_n = 1'b0;
        wait_neg(4);
        if (cs_first) bus_cs_n = 1'b1; else bus_wr_n = 1'b1;
        wait_neg(4);
        bus_cs_n = 1'b1;
        bus_wr_n = 1'b1;
        wait_neg(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_neg(4);
        chk("R1", "reg_a after reset", reg_a, 8'h00);
        chk("R1", "reg_b after reset", reg_b, 8'h00);
        chk("R1", "flag after reset", {7'b0, sel_violation}, 8'h00);
        rst_n = 1'b1;
        wait_neg(3);

        // R2 R3 R4 R5: table of writes
        for (int k = 0; k < 6; k++) begin
            bus_write(VECS[k].sel, VECS[k].data, VECS[k].cs_first);
            chk(VECS[k].sel ? "R3" : "R2", $sformatf("vec%0d reg_a", k), reg_a, VECS[k].exp_a);
            chk(VECS[k].cs_first ? "R5" : "R4", $sformatf("vec%0d reg_b", k), reg_b, VECS[k].exp_b);
        end

        // R6: no transparency while both strobes low
        bus_sel = 1'b0; bus_data = 8'h11;
        wait_neg(3);
        bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        wait_neg(4);
        bus_data = 8'h77;
        wait_neg(4);
        chk("R6", "reg_a held during low strobe", reg_a, 8'h3C);
        bus_wr_n = 1'b1;
        wait_neg(4);
        bus_cs_n = 1'b1;
        wait_neg(2);
        chk("R6", "reg_a gets byte from leading edge", reg_a, 8'h11);
        chk("R6", "reg_b untouched", reg_b, 8'h81);

        // R7: one strobe toggling while the other stays high
        bus_sel = 1'b1; bus_data = 8'hEE;
        wait_neg(3);
        bus_wr_n = 1'b0; wait_neg(4); bus_wr_n = 1'b1; wait_neg(4);
        bus_cs_n = 1'b0; wait_neg(4); bus_cs_n = 1'b1; wait_neg(4);
        chk("R7", "reg_a after lone strobes", reg_a, 8'h11);
        chk("R7", "reg_b after lone strobes", reg_b, 8'h81);

        // R8: latency of three clock edges
        bus_sel = 1'b0; bus_data = 8'h42;
        wait_neg(3);
        bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        wait_neg(4);
        bus_wr_n = 1'b1;
        wait_neg(2);
        chk("R8", "reg_a before third edge", reg_a, 8'h11);
        wait_neg(1);
        chk("R8", "reg_a at third edge", reg_a, 8'h42);
        bus_cs_n = 1'b1;
        wait_neg(4);

        // R9: select moves during active strobe
        chk("R9", "flag clear before violation", {7'b0, sel_violation}, 8'h00);
        bus_sel = 1'b0; bus_data = 8'h99;
        wait_neg(3);
        bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        wait_neg(4);
        bus_sel = 1'b1;
        wait_neg(4);
        chk("R9", "flag set on select change", {7'b0, sel_violation}, 8'h01);
        bus_wr_n = 1'b1;
        wait_neg(4);
        bus_cs_n = 1'b1;
        chk("R6", "load uses captured select", reg_a, 8'h99);
        chk("R6", "reg_b not loaded", reg_b, 8'h81);
        wait_neg(10);
        chk("R9", "flag stays set", {7'b0, sel_violation}, 8'h01);

        // R10: clear
        flag_clr = 1'b1;
        wait_neg(1);
        flag_clr = 1'b0;
        chk("R10", "flag after clear", {7'b0, sel_violation}, 8'h00);

        // R10: clear wins over a violation in progress
        bus_sel = 1'b0;
        wait_neg(3);
        bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        wait_neg(4);
        flag_clr = 1'b1;
        bus_sel = 1'b1;
        wait_neg(5);
        chk("R10", "clear holds flag low", {7'b0, sel_violation}, 8'h00);
        flag_clr = 1'b0;
        bus_cs_n = 1'b1; bus_wr_n = 1'b1;
        wait_neg(4);

        // R1: reset with strobes active and data on the bus
        bus_data = 8'hA5; bus_sel = 1'b1;
        bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        rst_n = 1'b0;
        wait_neg(3);
        chk("R1", "reg_a cleared under active bus", reg_a, 8'h00);
        chk("R1", "reg_b cleared under active bus", reg_b, 8'h00);
        chk("R1", "flag cleared by reset", {7'b0, sel_violation}, 8'h00);
        bus_cs_n = 1'b1; bus_wr_n = 1'b1;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(6);
        chk("R1", "reg_a stays zero after reset", reg_a, 8'h00);
        chk("R1", "reg_b stays zero after reset", reg_b, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule